// File: doc/BRIEF.md
# Sound Chip Bus Access Decoder

This block sits between a 16-bit host bus and a sound chip whose register file is reached through two ports: a select port that holds the number of the register in use, and a data port that reads or writes that register. The host sees a four-byte window. Only address bit 1 decides which port is addressed. Bit 0 distinguishes a primary (even) offset from a shadow (odd) offset.

A shadow offset is honoured for writes only when the host moves a single byte. A word or longword write that lands on a shadow offset is dropped. Such a write produces no strobe and no wait. Every accepted access raises a one-cycle wait request in the cycle after the access. Reads return live register data only at offset 0, and only while the selected register number is inside the register file. All other reads return all ones.

The decoder owns the full-width select value and presents it to the register file. It also issues single-cycle pulses for select writes, data writes and reads.

Top module: `sndbus_decoder`

## Requirements
- R1: After reset the selected index is 0, the strobes and the wait request are low, and the read data is 0xFF.
- R2: An accepted write with address bit 1 clear loads the full 8-bit write value into the selected index and pulses sel_wr for one cycle in the cycle after the access. With address bit 1 set, it pulses rf_wr with that value instead.
- R3: A byte-size write (size code 2'b00) to an odd offset (1 or 3) has the same effect as the same write to the even offset below it.
- R4: A write with size code word (2'b01) or long (2'b10) to an odd offset is dropped: no sel_wr, no rf_wr, no wait request, and the selected index is unchanged.
- R5: Every accepted access, read or write, raises wait_req for exactly one cycle, in the cycle after the access.
- R6: A read at offset 0 with a selected index below 16 returns the register file data presented during the access on bus_rdata in the next cycle, and pulses rf_rd.
- R7: Reads at offsets 1, 2 and 3 return 0xFF and do not pulse rf_rd, whatever the access size.
- R8: A read at offset 0 while the selected index is 16 or more returns 0xFF and does not pulse rf_rd.
- R9: A data-port write while the selected index is 16 or more produces no rf_wr, but it still raises wait_req.
- R10: The select value is kept at full width and not masked: a written index of 0x10 or above is presented unchanged on rf_index.
- R11: Word and long writes to even offsets are accepted like byte writes.
- R12: bus_rdata holds its value across every cycle that has no accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Byte offset inside the window |
| bus_size | input | 2 | 00 byte, 01 word, 10 long |
| bus_wdata | input | 8 | Byte driven toward the addressed port |
| bus_rdata | output | 8 | Read result, valid the cycle after a read |
| wait_req | output | 1 | One-cycle wait request per accepted access |
| rf_index | output | 8 | Currently selected register number |
| sel_wr | output | 1 | Pulse: select value was just written |
| rf_wr | output | 1 | Pulse: write rf_wdata into register rf_index |
| rf_wdata | output | 8 | Data-port write value |
| rf_rd | output | 1 | Pulse: register rf_index was read |
| rf_rdata | input | 8 | Register file content at rf_index |

## Verification
A corrupted select value shows on rf_index in the cycle after the select write. It then changes which register data a base read returns and whether data writes reach the register file. A wrong acceptance decision for shadow writes shows one cycle after the access as a wait pulse or strobe that should not be there, or as a missing one. It can also leave the index changed when it should not be. A stale or wrongly muxed read value shows on bus_rdata one cycle after the read. The value then persists until the next read, so it can also spoil later comparisons.

// File: rtl/sndbus_pkg.sv
package sndbus_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10
    } size_e;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_SELWR = 2'd1,
        K_DATWR = 2'd2,
        K_READ  = 2'd3
    } kind_e;
endpackage

// File: rtl/sndbus_classify.sv
module sndbus_classify
    import sndbus_pkg::*;
#(
    parameter int OFFW = 2
) (
    input  logic            valid,
    input  logic            write,
    input  logic [OFFW-1:0] addr,
    input  logic [1:0]      size,
    output logic            accept,
    output kind_e           kind,
    output logic            base
);
    logic shadow;
    logic is_byte;

    always_comb begin
        shadow  = addr[0];
        is_byte = (size == SZ_BYTE);
        base    = (addr == '0);
        kind    = K_NONE;
        accept  = 1'b0;
        if (valid) begin
            if (!write) begin
                kind   = K_READ;
                accept = 1'b1;
            end else if (!shadow || is_byte) begin
                kind   = addr[1] ? K_DATWR : K_SELWR;
                accept = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sndbus_rdmux.sv
module sndbus_rdmux #(
    parameter int DW   = 8,
    parameter int IDXW = 8,
    parameter int NREG = 16
) (
    input  logic            base,
    input  logic [IDXW-1:0] index,
    input  logic [DW-1:0]   rf_rdata,
    output logic            idx_ok,
    output logic [DW-1:0]   rd_value
);
    localparam logic [IDXW-1:0] LIMIT = IDXW'(NREG);

    always_comb begin
        idx_ok   = (index < LIMIT);
        rd_value = (base && idx_ok) ? rf_rdata : {DW{1'b1}};
    end
endmodule

// File: rtl/sndbus_decoder.sv
module sndbus_decoder
    import sndbus_pkg::*;
#(
    parameter int DW   = 8,
    parameter int IDXW = 8,
    parameter int NREG = 16,
    parameter int OFFW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_valid,
    input  logic            bus_write,
    input  logic [OFFW-1:0] bus_addr,
    input  logic [1:0]      bus_size,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            wait_req,
    output logic [IDXW-1:0] rf_index,
    output logic            sel_wr,
    output logic            rf_wr,
    output logic [DW-1:0]   rf_wdata,
    output logic            rf_rd,
    input  logic [DW-1:0]   rf_rdata
);
    typedef struct packed {
        logic [IDXW-1:0] index;
        logic            sel_wr;
        logic            dat_wr;
        logic [DW-1:0]   wdata;
        logic            rd;
        logic            wt;
        logic [DW-1:0]   rdata;
    } state_t;

    state_t st_d, st_q;

    logic          acc;
    kind_e         kind;
    logic          base;
    logic          idx_ok;
    logic [DW-1:0] rd_value;

    sndbus_classify #(.OFFW(OFFW)) u_classify (
        .valid  (bus_valid),
        .write  (bus_write),
        .addr   (bus_addr),
        .size   (bus_size),
        .accept (acc),
        .kind   (kind),
        .base   (base)
    );

    sndbus_rdmux #(.DW(DW), .IDXW(IDXW), .NREG(NREG)) u_rdmux (
        .base     (base),
        .index    (st_q.index),
        .rf_rdata (rf_rdata),
        .idx_ok   (idx_ok),
        .rd_value (rd_value)
    );

    always_comb begin
        st_d        = st_q;
        st_d.sel_wr = 1'b0;
        st_d.dat_wr = 1'b0;
        st_d.rd     = 1'b0;
        st_d.wt     = 1'b0;
        if (acc) begin
            st_d.wt = 1'b1;
            case (kind)
                K_SELWR: begin
                    st_d.index  = IDXW'(bus_wdata);
                    st_d.sel_wr = 1'b1;
                end
                K_DATWR: begin
                    if (idx_ok) begin
                        st_d.dat_wr = 1'b1;
                        st_d.wdata  = bus_wdata;
                    end
                end
                K_READ: begin
                    st_d.rdata = rd_value;
                    st_d.rd    = base && idx_ok;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.index  <= '0;
            st_q.sel_wr <= 1'b0;
            st_q.dat_wr <= 1'b0;
            st_q.wdata  <= '0;
            st_q.rd     <= 1'b0;
            st_q.wt     <= 1'b0;
            st_q.rdata  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign wait_req  = st_q.wt;
    assign rf_index  = st_q.index;
    assign sel_wr    = st_q.sel_wr;
    assign rf_wr     = st_q.dat_wr;
    assign rf_wdata  = st_q.wdata;
    assign rf_rd     = st_q.rd;
endmodule

// File: rtl/sndbus_decoder_chk.sv
module sndbus_decoder_chk #(
    parameter int DW   = 8,
    parameter int IDXW = 8,
    parameter int NREG = 16,
    parameter int OFFW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_valid,
    input logic            bus_write,
    input logic [OFFW-1:0] bus_addr,
    input logic [1:0]      bus_size,
    input logic [DW-1:0]   bus_rdata,
    input logic            wait_req,
    input logic [IDXW-1:0] rf_index,
    input logic            sel_wr,
    input logic            rf_wr,
    input logic            rf_rd
);
    localparam logic [IDXW-1:0] LIMIT = IDXW'(NREG);

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_wr, rf_wr, rf_rd}));

    a_r4_shadow_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr[0] && bus_size != 2'b00)
        |=> (!wait_req && !sel_wr && !rf_wr && $stable(rf_index)));

    a_r5_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> wait_req);

    a_r5_idle_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !wait_req);

    a_r7_nonbase_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr != '0) |=> (bus_rdata == '1 && !rf_rd));

    a_r8_range_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == '0 && rf_index >= LIMIT)
        |=> (bus_rdata == '1 && !rf_rd));

    a_r9_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |-> (rf_index < LIMIT));

    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

bind sndbus_decoder sndbus_decoder_chk #(
    .DW(DW), .IDXW(IDXW), .NREG(NREG), .OFFW(OFFW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_rdata (bus_rdata),
    .wait_req  (wait_req),
    .rf_index  (rf_index),
    .sel_wr    (sel_wr),
    .rf_wr     (rf_wr),
    .rf_rd     (rf_rd)
);

// File: tb/tb_sndbus_decoder.sv
module tb_sndbus_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0;
    logic       bus_write = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [1:0] bus_size = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       wait_req;
    logic [7:0] rf_index;
    logic       sel_wr;
    logic       rf_wr;
    logic [7:0] rf_wdata;
    logic       rf_rd;
    logic [7:0] rf_rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // register file stand-in: content is a fixed function of the index
    assign rf_rdata = 8'h5A ^ rf_index;

    sndbus_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wait_req(wait_req), .rf_index(rf_index), .sel_wr(sel_wr),
        .rf_wr(rf_wr), .rf_wdata(rf_wdata), .rf_rd(rf_rd), .rf_rdata(rf_rdata)
    );

    typedef struct {
        logic       sel_wr;
        logic       rf_wr;
        logic       rf_rd;
        logic       wt;
        logic [7:0] rdata;
        logic [7:0] index;
        logic [7:0] wdata;
        string      tag;
    } exp_t;

    exp_t q[$];
    logic [7:0] m_index = 8'h00;
    logic [7:0] m_rdata = 8'hFF;
    bit         done = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [1:0] a, input logic [1:0] sz,
                          input logic [7:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
        e.sel_wr = 0; e.rf_wr = 0; e.rf_rd = 0; e.wt = 0; e.wdata = 8'h00; e.tag = tag;
        if (wr) begin
            if (!a[0] || sz == 2'b00) begin
                e.wt = 1;
                if (!a[1]) begin
                    e.sel_wr = 1; m_index = d;
                end else if (m_index < 8'd16) begin
                    e.rf_wr = 1; e.wdata = d;
                end
            end
        end else begin
            e.wt = 1;
            if (a == 2'd0 && m_index < 8'd16) begin
                e.rf_rd = 1; m_rdata = 8'h5A ^ m_index;
            end else begin
                m_rdata = 8'hFF;
            end
        end
        e.rdata = m_rdata;
        e.index = m_index;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        bus_valid = 1'b0;
        e.sel_wr = 0; e.rf_wr = 0; e.rf_rd = 0; e.wt = 0; e.wdata = 8'h00;
        e.rdata = m_rdata; e.index = m_index; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "sel_wr", sel_wr, e.sel_wr);
                chk(e.tag, "rf_wr", rf_wr, e.rf_wr);
                chk(e.tag, "rf_rd", rf_rd, e.rf_rd);
                chk(e.tag, "wait_req", wait_req, e.wt);
                chk(e.tag, "bus_rdata", bus_rdata, e.rdata);
                chk(e.tag, "rf_index", rf_index, e.index);
                if (e.rf_wr) chk(e.tag, "rf_wdata", rf_wdata, e.wdata);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "rf_index", rf_index, 8'h00);
        chk("R1", "strobes", {sel_wr, rf_wr, rf_rd, wait_req}, 4'b0000);
        chk("R1", "bus_rdata", bus_rdata, 8'hFF);
        rst_n = 1'b1;
        idle("R1");
        // R2 select and data writes, R6 read back
        access(1, 2'd0, 2'b00, 8'h03, "R2");
        access(1, 2'd2, 2'b00, 8'hC4, "R2");
        access(0, 2'd0, 2'b00, 8'h00, "R6");
        idle("R12");
        idle("R12");
        // R3 shadow byte writes
        access(1, 2'd1, 2'b00, 8'h07, "R3");
        access(1, 2'd3, 2'b00, 8'h99, "R3");
        access(0, 2'd0, 2'b01, 8'h00, "R6");
        // R4 dropped shadow writes, word and long
        access(1, 2'd1, 2'b01, 8'h0B, "R4");
        access(1, 2'd1, 2'b10, 8'h0C, "R4");
        access(1, 2'd3, 2'b01, 8'h11, "R4");
        access(1, 2'd3, 2'b10, 8'h12, "R4");
        idle("R4");
        access(0, 2'd0, 2'b00, 8'h00, "R4");
        // R11 word and long to even offsets
        access(1, 2'd0, 2'b01, 8'h0E, "R11");
        access(1, 2'd2, 2'b10, 8'h3C, "R11");
        access(0, 2'd0, 2'b10, 8'h00, "R11");
        // R7 reads at non-base offsets, several sizes
        access(0, 2'd1, 2'b00, 8'h00, "R7");
        access(0, 2'd0, 2'b00, 8'h00, "R5");
        access(0, 2'd2, 2'b01, 8'h00, "R7");
        access(0, 2'd0, 2'b00, 8'h00, "R5");
        access(0, 2'd3, 2'b10, 8'h00, "R7");
        // R10 out-of-range index kept at full width; R8 and R9
        access(1, 2'd0, 2'b00, 8'h10, "R10");
        access(0, 2'd0, 2'b00, 8'h00, "R8");
        access(1, 2'd2, 2'b00, 8'h77, "R9");
        access(1, 2'd1, 2'b00, 8'hF3, "R10");
        access(0, 2'd0, 2'b00, 8'h00, "R8");
        access(1, 2'd3, 2'b00, 8'h55, "R9");
        // R5 back-to-back accepted accesses, then idle
        access(1, 2'd0, 2'b00, 8'h0F, "R5");
        access(0, 2'd0, 2'b00, 8'h00, "R5");
        access(1, 2'd2, 2'b00, 8'hAB, "R5");
        idle("R5");
        idle("R12");
        // R1 reset mid-run returns to reset state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "rf_index", rf_index, 8'h00);
        chk("R1", "bus_rdata", bus_rdata, 8'hFF);
        chk("R1", "wait_req", wait_req, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule